// File: doc/BRIEF.md
# Parallel NOR Memory Command Front End

This block models, clock by clock, the bus-facing command logic of a 16-bit parallel NOR-style memory. It takes the chip-enable, write-enable and output-enable strobes, an active-low device reset, a 22-bit address and a 16-bit data word. It decodes each bus cycle as a read, a write, standby or output-disabled. It follows multi-write command sequences, sends single-cycle requests to an internal program/erase sequencer, and chooses what a read returns: array contents, identification words, or nothing (bus released).

The three strobes, the address and the data are each passed through a two-flop synchroniser. Edges are then found on the synchronised copies. A write opens when both enables are low. The block latches the address at that moment, which is the later of the two falling edges. The write closes when either enable rises, which is the first rising edge, and the data is taken then. A command has effect only after two unlock writes. While the sequencer is busy, every command write is dropped.

Top module: `flash_cmd_if`

## Requirements
- R1: While `resetN` is low, `dataOe` is 0 and `dataOut` is 0. The decoder returns to array-read mode with no request pending.
- R2: `dataOe` is 1 only while the synchronised strobes show `ceN`=0, `oeN`=0, `weN`=1. In that state `dataOut` carries the selected read word. Standby (`ceN`=1) and output-disabled (`oeN`=1, `weN`=1) give `dataOe`=0 and `dataOut`=0. In read mode the read word is `arrayData`.
- R3: A write cycle is `ceN`=0, `weN`=0, `oeN`=1. Its address is the value present when the second enable falls. Its data is the value present when the first enable rises. This holds both when CE leads and when WE leads.
- R4: Four writes make a word program: 555h/AAh, 2AAh/55h, 555h/A0h, then any address with any data. After the fourth write, `progReq` pulses for one cycle with `progAddr`/`progData` equal to that write's address and data. Unlock addresses compare on address bits [10:0]. Command codes compare on data bits [7:0].
- R5: Six writes make a chip erase: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h. `eraseReq` pulses for one cycle after the sixth write.
- R6: The writes 555h/AAh, 2AAh/55h, 555h/90h enter identification mode. There a read with address bits [1:0]=00 returns 00C2h, and a read with bit 0 = 1 returns 22FCh.
- R7: In identification mode, a read with address bits [1:0]=10 returns 0088h when `lockedRegion`=1 and 0008h when it is 0.
- R8: Any write that does not fit the expected step returns the decoder to array-read mode without a request. This includes F0h. Any write made in identification mode also returns to array-read mode.
- R9: While `seqBusy` is 1, completed writes are dropped and leave the decoder state unchanged. `progReq` and `eraseReq` are asserted only if `seqBusy` was 0 when the completing write closed.
- R10: `progReq` and `eraseReq` are never 1 together, and each stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| resetN | input | 1 | Active-low device reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addrIn | input | 22 | Word address |
| dataIn | input | 16 | Write data from the bus |
| arrayData | input | 16 | Word read from the storage array |
| lockedRegion | input | 1 | Protected region is factory locked |
| seqBusy | input | 1 | Program/erase sequencer is running |
| dataOut | output | 16 | Read data toward the bus |
| dataOe | output | 1 | Drive enable for `dataOut` (0 = high impedance) |
| progReq | output | 1 | One-cycle program request |
| progAddr | output | 22 | Program target address |
| progData | output | 16 | Program data |
| eraseReq | output | 1 | One-cycle chip erase request |

## Verification
A strobe change made between clock edges shows on `dataOe`/`dataOut` two rising edges later, once the two synchroniser stages have passed it. A request appears one edge after that, so three edges after the strobe rise that closes the write. After every bus change the bench waits three full cycles and samples on the falling edge, which is past both latencies. Requests are counted by a falling-edge monitor. Their count and captured contents are compared after each sequence has settled, so the result does not depend on the exact request cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  parameter int ADDR_W = 22;
  parameter int DATA_W = 16;

  // completed write event handed from datapath to control
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } busEv_t;

  // control strobes back to the datapath
  typedef struct packed {
    logic idMode;
  } ctlStrb_t;

  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PGM, ST_ER0, ST_ER1, ST_ER2, ST_ID
  } cmdState_t;

endpackage

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              lockedRegion,
  input  ctlStrb_t          ctl,
  output busEv_t            ev,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [DATA_W-1:0] MFR_CODE  = DATA_W'(16'h00C2);
  localparam logic [DATA_W-1:0] DEV_CODE  = DATA_W'(16'h22FC);
  localparam logic [DATA_W-1:0] LOCK_YES  = DATA_W'(16'h0088);
  localparam logic [DATA_W-1:0] LOCK_NO   = DATA_W'(16'h0008);

  logic [2:0]        strbSh [SYNC_STAGES];
  logic [ADDR_W-1:0] addrSh [SYNC_STAGES];
  logic [DATA_W-1:0] dataSh [SYNC_STAGES];

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        strbSh[i] <= 3'b111;
        addrSh[i] <= '0;
        dataSh[i] <= '0;
      end
    end else begin
      strbSh[0] <= {ceN, weN, oeN};
      addrSh[0] <= addrIn;
      dataSh[0] <= dataIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        strbSh[i] <= strbSh[i-1];
        addrSh[i] <= addrSh[i-1];
        dataSh[i] <= dataSh[i-1];
      end
    end
  end

  logic ceS, weS, oeS;
  assign {ceS, weS, oeS} = strbSh[LAST];

  logic wrActNow, wrActPrev, wrPulse;
  logic [ADDR_W-1:0] addrLat;

  assign wrActNow = !ceS && !weS && oeS;
  assign wrPulse  = wrActPrev && !wrActNow;

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      wrActPrev <= 1'b0;
      addrLat   <= '0;
    end else begin
      wrActPrev <= wrActNow;
      if (wrActNow && !wrActPrev) addrLat <= addrSh[LAST];  // later falling enable
    end
  end

  assign ev.wr   = wrPulse;
  assign ev.addr = addrLat;
  assign ev.data = dataSh[LAST];                             // first rising enable

  logic rdAct;
  logic [DATA_W-1:0] idWord, rdWord;

  assign rdAct = !ceS && !oeS && weS;

  always_comb begin
    if (addrSh[LAST][0])      idWord = DEV_CODE;
    else if (addrSh[LAST][1]) idWord = lockedRegion ? LOCK_YES : LOCK_NO;
    else                      idWord = MFR_CODE;
  end

  assign rdWord  = ctl.idMode ? idWord : arrayData;
  assign dataOe  = resetN && rdAct;
  assign dataOut = dataOe ? rdWord : '0;

  p_wr_single_r3: assert property (@(posedge clk) disable iff (!resetN)
    wrPulse |=> !wrPulse);

  p_no_drive_on_write_r2: assert property (@(posedge clk) disable iff (!resetN)
    wrPulse |-> !dataOe);

endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int UNLOCK_BITS = 11
) (
  input  logic              clk,
  input  logic              resetN,
  input  busEv_t            ev,
  input  logic              seqBusy,
  output ctlStrb_t          ctl,
  output logic              progReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic              eraseReq
);

  localparam logic [UNLOCK_BITS-1:0] ADR_A = UNLOCK_BITS'(12'h555);
  localparam logic [UNLOCK_BITS-1:0] ADR_B = UNLOCK_BITS'(12'h2AA);
  localparam logic [7:0] C_UNL1 = 8'hAA, C_UNL2 = 8'h55, C_PGM = 8'hA0,
                         C_ERS = 8'h80, C_CHIP = 8'h10, C_ID = 8'h90;

  cmdState_t state, nextState;
  logic takeWr, atA, atB, unl1, unl2;
  logic [7:0] cmd;

  assign takeWr = ev.wr && !seqBusy;
  assign cmd    = ev.data[7:0];
  assign atA    = ev.addr[UNLOCK_BITS-1:0] == ADR_A;
  assign atB    = ev.addr[UNLOCK_BITS-1:0] == ADR_B;
  assign unl1   = atA && cmd == C_UNL1;
  assign unl2   = atB && cmd == C_UNL2;

  always_comb begin
    nextState = ST_READ;
    unique case (state)
      ST_READ: if (unl1) nextState = ST_UNL1;
      ST_UNL1: if (unl2) nextState = ST_UNL2;
      ST_UNL2: if (atA) begin
        if (cmd == C_PGM)      nextState = ST_PGM;
        else if (cmd == C_ERS) nextState = ST_ER0;
        else if (cmd == C_ID)  nextState = ST_ID;
      end
      ST_ER0:  if (unl1) nextState = ST_ER1;
      ST_ER1:  if (unl2) nextState = ST_ER2;
      default: nextState = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      state    <= ST_READ;
      progReq  <= 1'b0;
      eraseReq <= 1'b0;
      progAddr <= '0;
      progData <= '0;
    end else begin
      progReq  <= 1'b0;
      eraseReq <= 1'b0;
      if (takeWr) begin
        state <= nextState;
        if (state == ST_PGM) begin
          progReq  <= 1'b1;
          progAddr <= ev.addr;
          progData <= ev.data;
        end
        if (state == ST_ER2 && atA && cmd == C_CHIP) eraseReq <= 1'b1;
      end
    end
  end

  assign ctl.idMode = state == ST_ID;

  p_req_exclusive_r10: assert property (@(posedge clk) disable iff (!resetN)
    !(progReq && eraseReq));

  p_prog_pulse_r10: assert property (@(posedge clk) disable iff (!resetN)
    progReq |=> !progReq);

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!resetN)
    (progReq || eraseReq) |-> !$past(seqBusy));

  p_req_follows_write_r4: assert property (@(posedge clk) disable iff (!resetN)
    (progReq || eraseReq) |-> $past(ev.wr));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              resetN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [21:0]       addrIn,
  input  logic [15:0]       dataIn,
  input  logic [15:0]       arrayData,
  input  logic              lockedRegion,
  input  logic              seqBusy,
  output logic [15:0]       dataOut,
  output logic              dataOe,
  output logic              progReq,
  output logic [21:0]       progAddr,
  output logic [15:0]       progData,
  output logic              eraseReq
);

  busEv_t   ev;
  ctlStrb_t ctl;

  flash_cmd_dp #(.SYNC_STAGES(2)) uDp (
    .clk(clk), .resetN(resetN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .arrayData(arrayData),
    .lockedRegion(lockedRegion), .ctl(ctl), .ev(ev),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  flash_cmd_ctl #(.UNLOCK_BITS(11)) uCtl (
    .clk(clk), .resetN(resetN), .ev(ev), .seqBusy(seqBusy), .ctl(ctl),
    .progReq(progReq), .progAddr(progAddr), .progData(progData),
    .eraseReq(eraseReq)
  );

endmodule

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, resetN = 1'b0;
  logic ceN = 1, weN = 1, oeN = 1, lockedRegion = 0, seqBusy = 0;
  logic [21:0] addrIn = '0;
  logic [15:0] dataIn = '0, arrayData = 16'h5A3C;
  logic [15:0] dataOut, progData;
  logic [21:0] progAddr;
  logic dataOe, progReq, eraseReq;

  int checks = 0, failures = 0;
  int progCnt = 0, eraseCnt = 0;
  logic [21:0] gotAddr = '0;
  logic [15:0] gotData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_if uut (.*);

  always @(negedge clk) begin
    if (progReq) begin progCnt++; gotAddr = progAddr; gotData = progData; end
    if (eraseReq) eraseCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // write cycle; garbage address before latch, garbage data after capture
  task automatic wr(input logic [21:0] a, input logic [15:0] d, input bit ceFirst);
    @(negedge clk); oeN = 1; addrIn = 22'h3FFFFF; dataIn = 16'hDEAD;
    if (ceFirst) ceN = 0; else weN = 0;
    settle();
    addrIn = a;
    if (ceFirst) weN = 0; else ceN = 0;
    settle();
    addrIn = 22'h155555; dataIn = d;
    settle();
    if (ceFirst) weN = 1; else ceN = 1;
    settle();
    dataIn = 16'hBEEF;
    ceN = 1; weN = 1;
    settle();
  endtask

  task automatic rd(input logic [21:0] a, output logic [15:0] v, output logic oe);
    @(negedge clk); addrIn = a; weN = 1; ceN = 0; oeN = 0;
    settle(); v = dataOut; oe = dataOe;
    ceN = 1; oeN = 1; settle();
  endtask

  task automatic unlock(input bit cf);
    wr(22'h000555, 16'h00AA, cf);
    wr(22'h0002AA, 16'h0055, !cf);
  endtask

  task automatic t_reset();
    logic [15:0] v; logic oe;
    chk("R1 oe in reset", dataOe, 0);
    chk("R1 data in reset", dataOut, 0);
    ceN = 0; oeN = 0; settle();
    chk("R1 oe ignores strobes", dataOe, 0);
    ceN = 1; oeN = 1;
    resetN = 1; settle();
    rd(22'h10, v, oe);
    chk("R1 read mode after reset", v, 16'h5A3C);
  endtask

  task automatic t_bus();
    logic [15:0] v; logic oe;
    rd(22'h20, v, oe);
    chk("R2 read drives", oe, 1);
    chk("R2 array data", v, 16'h5A3C);
    @(negedge clk); ceN = 1; oeN = 0; settle();
    chk("R2 standby hiz", dataOe, 0);
    ceN = 0; oeN = 1; settle();
    chk("R2 output disable", dataOe, 0);
    chk("R2 data zero", dataOut, 0);
    ceN = 1; settle();
  endtask

  task automatic t_program(input bit cf, input logic [21:0] a, input logic [15:0] d);
    int p0 = progCnt;
    unlock(cf);
    wr(22'h000555, 16'h00A0, cf);
    wr(a, d, cf);
    chk("R4 one program request", progCnt - p0, 1);
    chk("R3 latched address", gotAddr, a);
    chk("R3 latched data", gotData, d);
  endtask

  task automatic t_erase();
    int e0 = eraseCnt, p0 = progCnt;
    unlock(1);
    wr(22'h000555, 16'h0080, 0);
    unlock(0);
    wr(22'h000555, 16'h0010, 1);
    chk("R5 one erase request", eraseCnt - e0, 1);
    chk("R10 no program on erase", progCnt - p0, 0);
  endtask

  task automatic t_ident();
    logic [15:0] v; logic oe;
    unlock(1);
    wr(22'h000555, 16'h0090, 1);
    rd(22'h000000, v, oe); chk("R6 manufacturer", v, 16'h00C2);
    rd(22'h000001, v, oe); chk("R6 device", v, 16'h22FC);
    rd(22'h000003, v, oe); chk("R6 device a1 set", v, 16'h22FC);
    lockedRegion = 1;
    rd(22'h000002, v, oe); chk("R7 locked", v, 16'h0088);
    lockedRegion = 0;
    rd(22'h000002, v, oe); chk("R7 unlocked", v, 16'h0008);
    wr(22'h000000, 16'h00F0, 0);
    rd(22'h000000, v, oe); chk("R8 F0 exits id", v, 16'h5A3C);
  endtask

  task automatic t_break();
    int p0 = progCnt, e0 = eraseCnt;
    unlock(1);
    wr(22'h000555, 16'h0000, 1);
    wr(22'h000123, 16'h4321, 1);
    chk("R8 bad command no request", progCnt - p0, 0);
    unlock(0);
    wr(22'h000555, 16'h00F0, 0);
    wr(22'h000555, 16'h00A0, 0);
    wr(22'h000124, 16'h1111, 0);
    chk("R8 F0 mid sequence", progCnt - p0, 0);
    unlock(1);
    wr(22'h000555, 16'h0080, 1);
    wr(22'h000555, 16'h0010, 1);
    chk("R8 broken erase", eraseCnt - e0, 0);
  endtask

  task automatic t_busy();
    logic [15:0] v; logic oe;
    int p0 = progCnt;
    seqBusy = 1;
    unlock(1);
    wr(22'h000555, 16'h00A0, 1);
    wr(22'h000200, 16'h7777, 1);
    chk("R9 busy drops program", progCnt - p0, 0);
    unlock(0);
    wr(22'h000555, 16'h0090, 0);
    seqBusy = 0;
    rd(22'h000000, v, oe);
    chk("R9 busy drops id entry", v, 16'h5A3C);
    wr(22'h000201, 16'h6666, 1);
    chk("R9 state unchanged", progCnt - p0, 0);
    unlock(1);
    wr(22'h000555, 16'h00A0, 1);
    seqBusy = 1;
    wr(22'h000202, 16'h5555, 0);
    seqBusy = 0;
    chk("R9 busy at data write", progCnt - p0, 0);
    wr(22'h000203, 16'h4444, 0);
    chk("R9 pgm state kept", progCnt - p0, 1);
    chk("R9 address after busy", gotAddr, 22'h000203);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bus();
    t_program(1, 22'h2ABCDE, 16'hA5F0);
    t_program(0, 22'h012345, 16'h0F5A);
    t_erase();
    t_ident();
    t_break();
    t_busy();
    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule